// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block sets the SCL timing of an I2C master. A reloadable down-counter advances on a count-enable strobe that runs at twice the instruction rate. Each full count-down from the reload value is one SCL half-period. When the count-down wraps, the block toggles SCL and raises a one-cycle rollover strobe that a bit-level sequencer uses to place its data and acknowledge work on SCL edges. One SCL period takes two rollovers, so the SCL frequency is the instruction rate divided by (reload + 1). For example, at a 10 MHz instruction rate a reload of 0x63 gives 100 kHz and 0x18 gives 400 kHz.

A start pulse begins counting. It fires when a byte is written for transmission. While the transfer runs, the counter reloads itself from the captured rate after every rollover. The sequencer raises a done pulse once the last bit and its acknowledge have finished. The counter then stops at zero and SCL stays at whatever level it had. A reload value of zero is not a legal rate, so a start that presents it is refused and no clock is made.

All pins are plain level or pulse controls. There is no data stream, so there is no valid/ready handshake and no back-pressure: pulses are acted on in the cycle they are sampled.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is asserted and after it is released, scl_o is high (1), roll_o is low (0), and the generator is stopped until a start is accepted.
- R2: A start_p sampled while stopped, with reload_val nonzero and done_p low, loads the counter with reload_val. The first rollover follows after reload_val + 1 count-enable strobes.
- R3: While running, consecutive rollovers are reload + 1 count-enable strobes apart, because the counter reloads automatically after each wrap. A full SCL period is therefore 2 × (reload + 1) strobes.
- R4: Each rollover inverts scl_o and holds roll_o high for exactly one clock, in the same cycle. scl_o changes at no other time.
- R5: The counter advances only in cycles with tick_en high. With tick_en held low, no rollover occurs.
- R6: A start_p presented with reload_val equal to 0 is ignored: the generator stays stopped and no rollover occurs.
- R7: A start_p sampled while running is ignored. Neither the count in progress nor the captured rate changes.
- R8: The rate is captured at the accepted start. Changing reload_val during a transfer has no effect on the rollover spacing.
- R9: A done_p stops the generator. No rollover follows, scl_o keeps its last level, and the count is cleared, so the next accepted start times from a fresh load.
- R10: A done_p sampled in the same cycle as a rollover takes priority: that rollover does not occur and scl_o does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count-enable strobe, twice the instruction rate |
| reload_val | input | 8 | Rate value; half-period is reload_val + 1 strobes |
| start_p | input | 1 | Transmit-buffer write pulse that starts the generator |
| done_p | input | 1 | Transfer-and-acknowledge complete pulse that stops it |
| scl_o | output | 1 | SCL level, high when idle after reset |
| roll_o | output | 1 | One-cycle strobe at each SCL edge |

## Verification
The hardest case to reach is a done pulse that lands in the very cycle a rollover would occur. Only that case shows that stopping beats the automatic reload. The bench gets there by running with the strobe high every cycle and waiting for one observed rollover. It then counts exactly reload clocks and raises done_p so that it is sampled on the predicted rollover edge. It checks that roll_o stays low and scl_o keeps its level, and it confirms the next start times from a fresh load.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;
endpackage

// File: rtl/scl_run_ctrl.sv
module scl_run_ctrl
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_p,
  input  logic             done_p,
  input  logic [CNT_W-1:0] reload_val,
  output gen_state_e       state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] rate_o
);
  gen_state_e       state_q;
  logic [CNT_W-1:0] rate_q;
  logic             rate_ok;

  // a zero rate cannot form a clock; refuse it at the door
  assign rate_ok = (reload_val != '0);
  assign load_o  = (state_q == GEN_IDLE) && start_p && !done_p && rate_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GEN_IDLE;
    end else if (done_p) begin
      state_q <= GEN_IDLE;
    end else if (load_o) begin
      state_q <= GEN_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
    end else if (load_o) begin
      rate_q <= reload_val;
    end
  end

  assign state_o = state_q;
  assign rate_o  = rate_q;
endmodule

// File: rtl/scl_half_cnt.sv
module scl_half_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] start_val_i,
  input  logic [CNT_W-1:0] rate_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;
  logic             step;

  assign at_zero = (cnt_q == '0);
  assign step    = run_i && tick_i && !stop_i;
  assign wrap_o  = step && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (stop_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= start_val_i;
    end else if (step) begin
      if (at_zero) cnt_q <= rate_i;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/scl_edge_out.sv
module scl_edge_out #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  output logic scl_o,
  output logic roll_o
);
  logic scl_q;
  logic roll_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= IDLE_LVL;
      roll_q <= 1'b0;
    end else begin
      roll_q <= wrap_i;
      if (wrap_i) scl_q <= ~scl_q;
    end
  end

  assign scl_o  = scl_q;
  assign roll_o = roll_q;
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
#(
  parameter int   CNT_W    = 8,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             start_p,
  input  logic             done_p,
  output logic             scl_o,
  output logic             roll_o
);
  gen_state_e       gen_st;
  logic             load_w;
  logic             run_w;
  logic             wrap_w;
  logic [CNT_W-1:0] rate_w;

  scl_run_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_p    (start_p),
    .done_p     (done_p),
    .reload_val (reload_val),
    .state_o    (gen_st),
    .load_o     (load_w),
    .rate_o     (rate_w)
  );

  assign run_w = (gen_st == GEN_RUN);

  scl_half_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_w),
    .load_i      (load_w),
    .stop_i      (done_p),
    .tick_i      (tick_en),
    .start_val_i (reload_val),
    .rate_i      (rate_w),
    .wrap_o      (wrap_w)
  );

  scl_edge_out #(.IDLE_LVL(IDLE_LVL)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap_i (wrap_w),
    .scl_o  (scl_o),
    .roll_o (roll_o)
  );
endmodule

// File: rtl/scl_rate_chk.sv
module scl_rate_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [CNT_W-1:0] reload_val,
  input logic             start_p,
  input logic             done_p,
  input logic             run_i,
  input logic             scl_o,
  input logic             roll_o
);
  // R4: a rollover strobe always coincides with an SCL inversion
  a_r4_roll_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |-> (scl_o != $past(scl_o)));

  // R4: without a strobe SCL holds
  a_r4_scl_only_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
    !roll_o |-> $stable(scl_o));

  // R4: strobe lasts one clock (smallest legal half-period is two strobes)
  a_r4_roll_single: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |=> !roll_o);

  // R5: a rollover needs a count-enable strobe in the cycle before
  a_r5_roll_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |-> $past(tick_en));

  // R6: zero rate never starts the generator
  a_r6_zero_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && start_p && reload_val == '0) |=> !run_i);

  // R7: a start while running does not stop or restart
  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && start_p && !done_p) |=> run_i);

  // R9: done stops the generator
  a_r9_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |=> !run_i);

  // R10: done beats a coincident rollover
  a_r10_done_prio: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |=> !roll_o);
endmodule

bind scl_rate_gen scl_rate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .reload_val (reload_val),
  .start_p    (start_p),
  .done_p     (done_p),
  .run_i      (run_w),
  .scl_o      (scl_o),
  .roll_o     (roll_o)
);

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en;
  logic [7:0] reload_val = 8'h00;
  logic       start_p = 1'b0;
  logic       done_p = 1'b0;
  logic       scl_o;
  logic       roll_o;

  int  n_run = 0;
  int  n_fail = 0;
  int  div = 1;
  int  phase = 0;
  bit  tick_on = 1'b1;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  // strobe generator: changes only at falling edges
  always @(negedge clk) phase <= (phase + 1 >= div) ? 0 : phase + 1;
  assign tick_en = tick_on && (phase == 0);

  scl_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reload_val(reload_val),
    .start_p(start_p), .done_p(done_p), .scl_o(scl_o), .roll_o(roll_o)
  );

  // {reload, strobe divisor, expected rollover gap in clocks}
  localparam logic [27:0] VEC [6] = '{
    {8'h63, 4'd1, 16'd100},
    {8'h18, 4'd1, 16'd25},
    {8'h01, 4'd1, 16'd2},
    {8'h09, 4'd2, 16'd20},
    {8'hFF, 4'd1, 16'd256},
    {8'h03, 4'd3, 16'd12}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_roll(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (roll_o) break;
      if (n > 4000) begin n = -1; break; end
    end
  endtask

  task automatic pulse_start(input logic [7:0] r);
    @(negedge clk);
    reload_val = r;
    start_p = 1'b1;
    @(negedge clk);
    start_p = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    done_p = 1'b1;
    @(negedge clk);
    done_p = 1'b0;
  endtask

  task automatic quiet(input int cyc, input logic lvl, input string req);
    int rolls = 0;
    int moved = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (roll_o) rolls++;
      if (scl_o !== lvl) moved++;
    end
    chk(rolls == 0, req, rolls, 0);
    chk(moved == 0, req, moved, 0);
  endtask

  initial begin
    int n;
    logic lvl;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(scl_o === 1'b1, "R1 scl in reset", int'(scl_o), 1);
    chk(roll_o === 1'b0, "R1 roll in reset", int'(roll_o), 0);
    rst_n = 1'b1;
    quiet(20, 1'b1, "R1 stopped after reset");

    // vector table: R2/R3/R5 rate across reloads and strobe rates
    foreach (VEC[k]) begin
      div = int'(VEC[k][19:16]);
      pulse_start(VEC[k][27:20]);
      wait_roll(n);
      lvl = scl_o;
      wait_roll(n);
      chk(n == int'(VEC[k][15:0]), "R3 rollover gap", n, int'(VEC[k][15:0]));
      chk(scl_o === ~lvl, "R4 scl toggles per roll", int'(scl_o), int'(~lvl));
      lvl = scl_o;
      pulse_done();
      quiet(40, lvl, "R9 hold after done");
    end
    div = 1;

    // R2: first rollover latency, strobe every clock
    pulse_start(8'h07);
    wait_roll(n);
    chk(n == 8, "R2 first rollover", n, 8);
    lvl = scl_o;
    pulse_done();
    quiet(20, lvl, "R9 stop");

    // R6: zero reload refused
    pulse_start(8'h00);
    quiet(60, lvl, "R6 zero reload");
    pulse_start(8'h04);
    wait_roll(n);
    chk(n == 5, "R6 idle after zero start", n, 5);
    lvl = scl_o;
    pulse_done();

    // R5: strobe held low, no progress
    tick_on = 1'b0;
    pulse_start(8'h02);
    quiet(40, lvl, "R5 no strobe");
    tick_on = 1'b1;
    wait_roll(n);
    chk(n == 3, "R5 count after strobe returns", n, 3);
    lvl = scl_o;
    pulse_done();

    // R7 + R8: start held and reload changed while running
    pulse_start(8'h0A);
    wait_roll(n);
    reload_val = 8'h03;
    start_p = 1'b1;
    wait_roll(n);
    chk(n == 11, "R7 start while running ignored", n, 11);
    reload_val = 8'h01;
    wait_roll(n);
    chk(n == 11, "R8 rate captured at start", n, 11);
    start_p = 1'b0;
    lvl = scl_o;
    pulse_done();
    quiet(20, lvl, "R9 stop");

    // R10: done on the rollover edge
    pulse_start(8'h05);
    wait_roll(n);
    lvl = scl_o;
    repeat (5) @(negedge clk);
    done_p = 1'b1;
    @(negedge clk);
    done_p = 1'b0;
    chk(roll_o === 1'b0, "R10 done beats rollover", int'(roll_o), 0);
    quiet(30, lvl, "R10 hold");
    pulse_start(8'h05);
    wait_roll(n);
    chk(n == 6, "R9 fresh load after done", n, 6);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(scl_o === 1'b1, "R1 scl after mid-run reset", int'(scl_o), 1);
    rst_n = 1'b1;
    quiet(40, 1'b1, "R1 stopped after mid-run reset");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule